// File: doc/BRIEF.md
# Feature Control Register with One-Shot Test Unlock

This block is a single 16-bit control and status register on a simple synchronous register bus. The bus has a select line that is already decoded from the address, a write strobe, a read strobe, write data and read data. The register holds five plain feature-enable bits and passes them straight to other logic as output pins. It also holds a sticky counter-overflow interrupt flag with its own mask bit, and a test-enable bit. The combined interrupt request is registered. The test-enable bit only drives a write-permit output; the test registers it unlocks belong to other logic.

The test-enable bit is governed by a three-state lock machine:
- `LK_PRISTINE`: no write since reset.
- `LK_ENABLED`: the test bit reads 1.
- `LK_SEALED`: the test bit reads 0 and can no longer be set.

Lock transitions:
- `PRISTINE->ENABLED`: first write with bit 15 = 1.
- `PRISTINE->SEALED`: first write with bit 15 = 0.
- `ENABLED->SEALED`: any later write with bit 15 = 0.
- `ENABLED->ENABLED`: a later write with bit 15 = 1.
- `SEALED` only leaves through reset.

The overflow flag is a two-state machine:
- `OV_IDLE->OV_PENDING`: an overflow event when no stop command is present.
- `OV_PENDING->OV_IDLE`: a stop command, or a write-one-to-clear with no event in the same cycle.

Top module: `fcr_ctrl`

## Requirements
- R1: After reset the test bit (bit 15) becomes 1 only when the first register write after reset carries a 1 in bit 15. Any write at all counts as the first write.
- R2: Once a 0 has been written to bit 15, the test bit stays 0 until reset, whatever is written later.
- R3: `test_wr_permit` equals the test bit, and a register read returns the same value in bit 15.
- R4: A one-cycle pulse on `miss_ovf` sets the overflow flag. The flag reads back in bit 9 from the next cycle on and stays set until it is cleared.
- R5: Writing 1 to bit 9 clears the overflow flag. Writing 0 to bit 9 leaves it unchanged.
- R6: `stop_cmd` clears the overflow flag and takes priority over a `miss_ovf` pulse in the same cycle.
- R7: When `miss_ovf` and a write-one-to-clear of bit 9 arrive in the same cycle, the flag stays set.
- R8: `irq` is registered. It equals (overflow flag AND NOT mask bit 8) as those bits stood one cycle earlier.
- R9: The feature bits are written directly and read back in these positions:
  - bit 14: burst-counter disable
  - bit 13: bus-activity-timer enable
  - bit 12: transmit-poll disable
  - bit 11: auto-pad transmit
  - bit 10: auto-strip receive
  - bit 8: overflow mask

  Each feature bit drives its output pin. All of them reset to 0.
- R10: Bits 7..0 are ignored on write and read as 0. `reg_rdata` is 0 whenever no read is selected.
- R11: A write strobe while `reg_sel` is low changes no bit and does not count as the first write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 1 | Address decode hit for this register |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, 0 when not read |
| stop_cmd | input | 1 | Stop command, clears overflow flag |
| miss_ovf | input | 1 | Overflow pulse from the missed-frame counter |
| test_wr_permit | output | 1 | Permit for writes to test-mode registers |
| burst_cnt_dis | output | 1 | Burst transaction counter disable |
| bus_timer_en | output | 1 | Bus activity timer enable |
| tx_poll_dis | output | 1 | Transmit polling disable |
| tx_auto_pad | output | 1 | Automatic transmit padding enable |
| rx_auto_strip | output | 1 | Automatic receive pad stripping enable |
| irq | output | 1 | Registered interrupt request |

## Verification
The assertions take for granted that `miss_ovf` and `stop_cmd` are synchronous to `clk`. They also assume that a write counts only when `reg_sel` and `reg_wr` are high together. The read assertion assumes read data is looked at only while `reg_sel` and `reg_rd` are both high. The stimulus drives every strobe one clock at a time, away from the active edge. It sweeps all three-write sequences of the test bit from reset and every combination of the six writable feature and mask bits. It also places each overflow-flag collision (event with clear, event with stop) in a single cycle.

// File: rtl/fcr_pkg.sv
package fcr_pkg;
    localparam int REG_W         = 16;
    localparam int BIT_TEST      = 15;
    localparam int BIT_BURST_DIS = 14;
    localparam int BIT_TIMER     = 13;
    localparam int BIT_POLL_DIS  = 12;
    localparam int BIT_APAD      = 11;
    localparam int BIT_ASTRIP    = 10;
    localparam int BIT_OVF       = 9;
    localparam int BIT_MASK      = 8;
    localparam int FEAT_LO       = BIT_ASTRIP;
    localparam int FEAT_HI       = BIT_BURST_DIS;
    localparam int FEAT_N        = FEAT_HI - FEAT_LO + 1;
    localparam int BANK_N        = FEAT_N + 1;   // features plus mask

    typedef enum logic [1:0] {
        LK_PRISTINE = 2'd0,
        LK_ENABLED  = 2'd1,
        LK_SEALED   = 2'd2
    } lock_state_t;

    typedef enum logic {
        OV_IDLE    = 1'b0,
        OV_PENDING = 1'b1
    } ovf_state_t;
endpackage

// File: rtl/fcr_lock_fsm.sv
module fcr_lock_fsm
    import fcr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_hit,
    input  logic wr_test_bit,
    output logic test_en
);
    lock_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LK_PRISTINE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_PRISTINE: if (wr_hit) state_d = wr_test_bit ? LK_ENABLED : LK_SEALED;
            LK_ENABLED:  if (wr_hit && !wr_test_bit) state_d = LK_SEALED;
            LK_SEALED:   state_d = LK_SEALED;
            default:     state_d = LK_SEALED;
        endcase
    end

    always_comb begin
        test_en = (state_q == LK_ENABLED);
    end
endmodule

// File: rtl/fcr_ovf_fsm.sv
module fcr_ovf_fsm
    import fcr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic stop_cmd,
    input  logic ovf_event,
    input  logic w1c,
    input  logic mask,
    output logic flag,
    output logic irq
);
    ovf_state_t state_q, state_d;
    logic       irq_q;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= OV_IDLE;
        else        state_q <= state_d;
    end

    // priority: stop, then event, then write-one-to-clear
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OV_IDLE: begin
                if (!stop_cmd && ovf_event) state_d = OV_PENDING;
            end
            OV_PENDING: begin
                if (stop_cmd)                state_d = OV_IDLE;
                else if (!ovf_event && w1c)  state_d = OV_IDLE;
            end
            default: state_d = OV_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= (state_q == OV_PENDING) && !mask;
    end

    always_comb begin
        flag = (state_q == OV_PENDING);
        irq  = irq_q;
    end
endmodule

// File: rtl/fcr_feature_bank.sv
module fcr_feature_bank #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_hit,
    input  logic [N-1:0] wr_bits,
    output logic [N-1:0] q
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        logic b_q;
        always_ff @(posedge clk) begin
            if (!rst_n)      b_q <= 1'b0;
            else if (wr_hit) b_q <= wr_bits[i];
        end
        assign q[i] = b_q;
    end
endmodule

// File: rtl/fcr_ctrl.sv
module fcr_ctrl
    import fcr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_sel,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             stop_cmd,
    input  logic             miss_ovf,
    output logic             test_wr_permit,
    output logic             burst_cnt_dis,
    output logic             bus_timer_en,
    output logic             tx_poll_dis,
    output logic             tx_auto_pad,
    output logic             rx_auto_strip,
    output logic             irq
);
    logic              wr_hit;
    logic              rd_hit;
    logic              test_en;
    logic              ovf_flag;
    logic              mask_bit;
    logic [BANK_N-1:0] bank_wr;
    logic [BANK_N-1:0] bank_q;
    logic [REG_W-1:0]  view;

    assign wr_hit = reg_sel && reg_wr;
    assign rd_hit = reg_sel && reg_rd;

    // bank bit 0 is the mask, bits 1..FEAT_N are the feature bits
    assign bank_wr = {reg_wdata[FEAT_HI:FEAT_LO], reg_wdata[BIT_MASK]};

    fcr_lock_fsm u_lock (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_hit      (wr_hit),
        .wr_test_bit (reg_wdata[BIT_TEST]),
        .test_en     (test_en)
    );

    fcr_feature_bank #(.N(BANK_N)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_hit  (wr_hit),
        .wr_bits (bank_wr),
        .q       (bank_q)
    );

    assign mask_bit = bank_q[0];

    fcr_ovf_fsm u_ovf (
        .clk       (clk),
        .rst_n     (rst_n),
        .stop_cmd  (stop_cmd),
        .ovf_event (miss_ovf),
        .w1c       (wr_hit && reg_wdata[BIT_OVF]),
        .mask      (mask_bit),
        .flag      (ovf_flag),
        .irq       (irq)
    );

    always_comb begin
        view                  = '0;
        view[BIT_TEST]        = test_en;
        view[FEAT_HI:FEAT_LO] = bank_q[BANK_N-1:1];
        view[BIT_OVF]         = ovf_flag;
        view[BIT_MASK]        = mask_bit;
        reg_rdata             = rd_hit ? view : '0;
    end

    assign test_wr_permit = test_en;
    assign burst_cnt_dis  = bank_q[BIT_BURST_DIS - FEAT_LO + 1];
    assign bus_timer_en   = bank_q[BIT_TIMER     - FEAT_LO + 1];
    assign tx_poll_dis    = bank_q[BIT_POLL_DIS  - FEAT_LO + 1];
    assign tx_auto_pad    = bank_q[BIT_APAD      - FEAT_LO + 1];
    assign rx_auto_strip  = bank_q[BIT_ASTRIP    - FEAT_LO + 1];
endmodule

// File: rtl/fcr_ctrl_chk.sv
module fcr_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_sel,
    input logic        reg_wr,
    input logic        reg_rd,
    input logic [15:0] reg_wdata,
    input logic [15:0] reg_rdata,
    input logic        stop_cmd,
    input logic        miss_ovf,
    input logic        test_wr_permit,
    input logic [4:0]  feat,
    input logic        ovf_flag,
    input logic        mask_bit,
    input logic        irq
);
    logic wrote_q;
    logic sealed_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wrote_q  <= 1'b0;
            sealed_q <= 1'b0;
        end else if (reg_sel && reg_wr) begin
            wrote_q <= 1'b1;
            if (!reg_wdata[15]) sealed_q <= 1'b1;
        end
    end

    AST_SET_ONLY_ON_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(test_wr_permit) |-> ($past(reg_sel && reg_wr && reg_wdata[15]) && !$past(wrote_q))); // R1
    AST_SEALED_STAYS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        sealed_q |-> !test_wr_permit); // R2
    AST_PERMIT_READS_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel && reg_rd) |-> (reg_rdata[15] == test_wr_permit)); // R3
    AST_EVENT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_ovf && !stop_cmd) |=> ovf_flag); // R4
    AST_STOP_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        stop_cmd |=> !ovf_flag); // R6
    AST_IRQ_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        irq == $past(ovf_flag && !mask_bit)); // R8
    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[7:0] == 8'h00); // R10
    AST_UNSELECTED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_sel && reg_wr) |=> $stable({feat, mask_bit})); // R11
endmodule

bind fcr_ctrl fcr_ctrl_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .reg_sel        (reg_sel),
    .reg_wr         (reg_wr),
    .reg_rd         (reg_rd),
    .reg_wdata      (reg_wdata),
    .reg_rdata      (reg_rdata),
    .stop_cmd       (stop_cmd),
    .miss_ovf       (miss_ovf),
    .test_wr_permit (test_wr_permit),
    .feat           ({burst_cnt_dis, bus_timer_en, tx_poll_dis, tx_auto_pad, rx_auto_strip}),
    .ovf_flag       (ovf_flag),
    .mask_bit       (mask_bit),
    .irq            (irq)
);

// File: tb/fcr_ctrl_test.sv
`timescale 1ns/1ps
module fcr_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_sel = 1'b0, reg_wr = 1'b0, reg_rd = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        stop_cmd = 1'b0, miss_ovf = 1'b0;
    logic        test_wr_permit, burst_cnt_dis, bus_timer_en, tx_poll_dis;
    logic        tx_auto_pad, rx_auto_strip, irq;
    int          n_cmp = 0, n_bad = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    fcr_ctrl uut (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .stop_cmd(stop_cmd), .miss_ovf(miss_ovf),
        .test_wr_permit(test_wr_permit), .burst_cnt_dis(burst_cnt_dis), .bus_timer_en(bus_timer_en),
        .tx_poll_dis(tx_poll_dis), .tx_auto_pad(tx_auto_pad), .rx_auto_strip(rx_auto_strip), .irq(irq)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic do_write(input logic [15:0] d, input logic sel = 1'b1);
        @(negedge clk); reg_sel = sel; reg_wr = 1'b1; reg_wdata = d;
        @(negedge clk); reg_sel = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic do_read(output logic [15:0] v);
        @(negedge clk); reg_sel = 1'b1; reg_rd = 1'b1;
        #1 v = reg_rdata;
        reg_sel = 1'b0; reg_rd = 1'b0;
    endtask

    task automatic pulse(input logic ev, input logic st, input logic [15:0] wd, input logic wr);
        @(negedge clk); miss_ovf = ev; stop_cmd = st; reg_sel = wr; reg_wr = wr; reg_wdata = wd;
        @(negedge clk); miss_ovf = 0; stop_cmd = 0; reg_sel = 0; reg_wr = 0; reg_wdata = '0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : main
        logic [15:0] v, exp;
        logic        en_m, fresh_m;
        do_reset();
        // R9 reset state, R10 idle read data
        #1 check("R9 reset outputs",
                 {10'd0, test_wr_permit, burst_cnt_dis, bus_timer_en, tx_poll_dis, tx_auto_pad, rx_auto_strip},
                 16'h0000);
        check("R10 idle rdata", reg_rdata, 16'h0000);
        check("R8 reset irq", {15'd0, irq}, 16'h0000);
        do_read(v); check("R9 reset readback", v, 16'h0000);

        // R1 R2 R3: all three-write sequences of the test bit
        for (int s = 0; s < 8; s++) begin
            do_reset();
            fresh_m = 1'b1; en_m = 1'b0;
            for (int k = 0; k < 3; k++) begin
                logic b;
                b = s[2-k];
                do_write({b, 15'h0});
                en_m = fresh_m ? b : (en_m & b);
                fresh_m = 1'b0;
                #1 check("R1 R2 permit", {15'd0, test_wr_permit}, {15'd0, en_m});
                do_read(v); check("R3 bit15 readback", {15'd0, v[15]}, {15'd0, en_m});
            end
        end

        // R11: unselected write is not the first write
        do_reset();
        do_write(16'hFFFF, 1'b0);
        do_read(v); check("R11 unselected write", v, 16'h0000);
        do_write(16'h8000);
        #1 check("R11 R1 first selected write", {15'd0, test_wr_permit}, 16'h0001);

        // R9 R10: every feature/mask combination, reserved bits driven high
        for (int k = 0; k < 64; k++) begin
            logic [5:0] c;
            c = k[5:0];
            do_write({1'b1, c[5:1], 1'b0, c[0], 8'hFF});
            exp = {1'b1, c[5:1], 1'b0, c[0], 8'h00};
            do_read(v); check("R9 R10 readback", v, exp);
            #1 check("R9 feature pins",
                     {11'd0, burst_cnt_dis, bus_timer_en, tx_poll_dis, tx_auto_pad, rx_auto_strip},
                     {11'd0, c[5:1]});
        end

        // overflow flag
        do_reset();
        pulse(1, 0, 16'h0, 0);
        do_read(v); check("R4 flag set", v, 16'h0200);
        @(negedge clk); #1 check("R8 irq unmasked", {15'd0, irq}, 16'h0001);
        do_write(16'h0000);
        do_read(v); check("R5 write zero keeps flag", v, 16'h0200);
        do_write(16'h0200);
        do_read(v); check("R5 w1c clears", v, 16'h0000);
        @(negedge clk); #1 check("R8 irq drops", {15'd0, irq}, 16'h0000);
        pulse(1, 0, 16'h0, 0);
        pulse(1, 0, 16'h0200, 1);
        do_read(v); check("R7 event beats w1c", v, 16'h0200);
        pulse(0, 1, 16'h0, 0);
        do_read(v); check("R6 stop clears", v, 16'h0000);
        pulse(1, 1, 16'h0, 0);
        do_read(v); check("R6 stop beats event", v, 16'h0000);
        do_write(16'h0100);
        pulse(1, 0, 16'h0, 0);
        @(negedge clk); #1 check("R8 masked irq", {15'd0, irq}, 16'h0000);
        do_read(v); check("R4 R8 flag while masked", v, 16'h0300);
        do_write(16'h0000);
        @(negedge clk); #1 check("R8 unmask irq", {15'd0, irq}, 16'h0001);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule